// File: doc/BRIEF.md
# Microprogram Sequencer with Dispatch Tables

This block is the control store and next-address logic of a microcoded multicycle processor controller. A micro-PC addresses a small control ROM. Each ROM word holds a set of datapath control fields and a 2-bit sequencing field. The control fields of the word at the current micro-PC drive the datapath directly through the output pins, so the outputs are combinational from the micro-PC register and the opcode.

The sequencing field picks the next micro-PC in one of three ways:
- step to the following word;
- return to the fetch word;
- jump through one of two lookup tables indexed by the instruction-register opcode.

The first table splits instructions after decode. The second separates loads from stores after the address computation. The datapath units the fields steer are outside this block.

The opcode is a plain level input taken from the instruction register. It is read only when a dispatch word is current. The pins have no handshake, because one micro-step is taken on every clock.

Top module: `useq_sequencer`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, upc is 0 and the fetch word is presented. Reset is asynchronous.
- R2: The sequencing code 3 (step) loads upc with upc+1 at the next clock.
- R3: The sequencing code 0 (fetch) loads upc with 0 at the next clock.
- R4: The sequencing code 1 uses the first table. Opcode 6'h23 (load) and 6'h2B (store) go to 2, opcode 6'h00 (register ALU op) goes to 6, 6'h04 (branch-if-equal) goes to 8, and 6'h02 (jump) goes to 9.
- R5: The sequencing code 2 uses the second table, indexed by the opcode present in that cycle. Opcode 6'h23 goes to 3 and 6'h2B goes to 5.
- R6: In either table, any opcode without an entry sends upc to 0.
- R7: The ROM layout is: 0 fetch (step), 1 decode (table 1), 2 address compute (table 2), 3 load read (step), 4 load write-back (fetch), 5 store (fetch), 6 ALU execute (step), 7 ALU write-back (fetch), 8 branch (fetch), 9 jump (fetch). Every other address holds an all-zero word with the fetch code.
- R8: Each word asserts only its own fields, and every other output is 0. The fields are listed as {pc_src, alu_op, alu_a_sel, alu_b_sel} and flags:
  - 0: mem_rd, ir_load, pc_load, alu_b_sel=01
  - 1: alu_b_sel=11
  - 2: alu_a_sel, alu_b_sel=10
  - 3: mem_rd, addr_sel
  - 4: reg_wr, wb_sel
  - 5: mem_wr, addr_sel
  - 6: alu_a_sel, alu_op=10
  - 7: reg_wr, reg_dst
  - 8: alu_a_sel, alu_op=01, pc_load_cond, pc_src=01
  - 9: pc_load, pc_src=10
- R9: mem_rd and mem_wr are never high together, and pc_load and pc_load_cond are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field from the instruction register |
| upc | output | 4 | Current micro-PC |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| addr_sel | output | 1 | Memory address source: 0 PC, 1 ALU result register |
| ir_load | output | 1 | Instruction register load |
| pc_load | output | 1 | Unconditional PC load |
| pc_load_cond | output | 1 | PC load when the ALU zero flag is set |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| reg_wr | output | 1 | Register file write enable |
| reg_dst | output | 1 | Destination register select: 0 rt, 1 rd |
| wb_sel | output | 1 | Write-back data: 0 ALU result, 1 memory data |
| seq_mode | output | 2 | Sequencing code of the current word |

## Verification
Every defined opcode is run from fetch to fetch, and two undefined opcodes are run as well. Each one takes a distinct path through the tables, so the upc traces show which table was consulted and which entry was selected. The load and store traces differ only after address 2, so they isolate the second table. Each undefined opcode returns to fetch straight after decode, which isolates the miss path of the first table. Directed runs change the opcode while address 2 is current, to show that the second table decodes the live opcode and that a miss there returns to 0. A reset in the middle of an instruction checks that the asynchronous clear reaches upc.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int OP_W  = 6;
  localparam int UPC_W = 4;

  typedef enum logic [1:0] {
    SQ_FETCH = 2'b00,
    SQ_DISP1 = 2'b01,
    SQ_DISP2 = 2'b10,
    SQ_NEXT  = 2'b11
  } seq_mode_e;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       addr_sel;
    logic       ir_load;
    logic       pc_load;
    logic       pc_load_cond;
    logic [1:0] pc_src;
    logic [1:0] alu_op;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic       reg_wr;
    logic       reg_dst;
    logic       wb_sel;
  } ctl_t;

  typedef struct packed {
    ctl_t      ctl;
    seq_mode_e seq;
  } uword_t;

  localparam logic [OP_W-1:0] OPC_ALU  = 6'h00;
  localparam logic [OP_W-1:0] OPC_JUMP = 6'h02;
  localparam logic [OP_W-1:0] OPC_BEQ  = 6'h04;
  localparam logic [OP_W-1:0] OPC_LOAD = 6'h23;
  localparam logic [OP_W-1:0] OPC_STOR = 6'h2B;

  localparam int UA_FETCH  = 0;
  localparam int UA_DECODE = 1;
  localparam int UA_MADDR  = 2;
  localparam int UA_LDRD   = 3;
  localparam int UA_LDWB   = 4;
  localparam int UA_STWR   = 5;
  localparam int UA_ALUEX  = 6;
  localparam int UA_ALUWB  = 7;
  localparam int UA_BEQ    = 8;
  localparam int UA_JUMP   = 9;
endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int UPC_W = useq_pkg::UPC_W
) (
  input  logic [UPC_W-1:0] addr,
  output uword_t           word
);
  always_comb begin
    word     = '0;
    word.seq = SQ_FETCH;
    case (int'(addr))
      UA_FETCH: begin
        word.ctl.mem_rd    = 1'b1;
        word.ctl.ir_load   = 1'b1;
        word.ctl.pc_load   = 1'b1;
        word.ctl.alu_b_sel = 2'b01;
        word.seq           = SQ_NEXT;
      end
      UA_DECODE: begin
        word.ctl.alu_b_sel = 2'b11;
        word.seq           = SQ_DISP1;
      end
      UA_MADDR: begin
        word.ctl.alu_a_sel = 1'b1;
        word.ctl.alu_b_sel = 2'b10;
        word.seq           = SQ_DISP2;
      end
      UA_LDRD: begin
        word.ctl.mem_rd   = 1'b1;
        word.ctl.addr_sel = 1'b1;
        word.seq          = SQ_NEXT;
      end
      UA_LDWB: begin
        word.ctl.reg_wr = 1'b1;
        word.ctl.wb_sel = 1'b1;
      end
      UA_STWR: begin
        word.ctl.mem_wr   = 1'b1;
        word.ctl.addr_sel = 1'b1;
      end
      UA_ALUEX: begin
        word.ctl.alu_a_sel = 1'b1;
        word.ctl.alu_op    = 2'b10;
        word.seq           = SQ_NEXT;
      end
      UA_ALUWB: begin
        word.ctl.reg_wr  = 1'b1;
        word.ctl.reg_dst = 1'b1;
      end
      UA_BEQ: begin
        word.ctl.alu_a_sel    = 1'b1;
        word.ctl.alu_op       = 2'b01;
        word.ctl.pc_load_cond = 1'b1;
        word.ctl.pc_src       = 2'b01;
      end
      UA_JUMP: begin
        word.ctl.pc_load = 1'b1;
        word.ctl.pc_src  = 2'b10;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int TABLE_SEL = 1,
  parameter int OP_W      = useq_pkg::OP_W,
  parameter int UPC_W     = useq_pkg::UPC_W
) (
  input  logic [OP_W-1:0]  opcode,
  output logic [UPC_W-1:0] target
);
  generate
    if (TABLE_SEL == 1) begin : g_after_decode
      always_comb begin
        case (opcode)
          OPC_LOAD, OPC_STOR: target = UPC_W'(UA_MADDR);
          OPC_ALU:            target = UPC_W'(UA_ALUEX);
          OPC_BEQ:            target = UPC_W'(UA_BEQ);
          OPC_JUMP:           target = UPC_W'(UA_JUMP);
          default:            target = UPC_W'(UA_FETCH);
        endcase
      end
    end else begin : g_after_addr
      always_comb begin
        case (opcode)
          OPC_LOAD: target = UPC_W'(UA_LDRD);
          OPC_STOR: target = UPC_W'(UA_STWR);
          default:  target = UPC_W'(UA_FETCH);
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int UPC_W = useq_pkg::UPC_W
) (
  input  logic [UPC_W-1:0] upc,
  input  seq_mode_e        seq,
  input  logic [UPC_W-1:0] tgt1,
  input  logic [UPC_W-1:0] tgt2,
  output logic [UPC_W-1:0] nxt
);
  always_comb begin
    case (seq)
      SQ_DISP1: nxt = tgt1;
      SQ_DISP2: nxt = tgt2;
      SQ_NEXT:  nxt = upc + 1'b1;
      default:  nxt = '0;
    endcase
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int OP_W  = useq_pkg::OP_W,
  parameter int UPC_W = useq_pkg::UPC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  opcode,
  output logic [UPC_W-1:0] upc,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             addr_sel,
  output logic             ir_load,
  output logic             pc_load,
  output logic             pc_load_cond,
  output logic [1:0]       pc_src,
  output logic [1:0]       alu_op,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic             reg_wr,
  output logic             reg_dst,
  output logic             wb_sel,
  output logic [1:0]       seq_mode
);
  uword_t           word;
  logic [UPC_W-1:0] tgt1, tgt2, nxt;

  useq_rom #(.UPC_W(UPC_W)) u_rom (.addr(upc), .word(word));

  useq_dispatch #(.TABLE_SEL(1), .OP_W(OP_W), .UPC_W(UPC_W)) u_disp1 (
    .opcode(opcode), .target(tgt1));
  useq_dispatch #(.TABLE_SEL(2), .OP_W(OP_W), .UPC_W(UPC_W)) u_disp2 (
    .opcode(opcode), .target(tgt2));

  useq_next #(.UPC_W(UPC_W)) u_next (
    .upc(upc), .seq(word.seq), .tgt1(tgt1), .tgt2(tgt2), .nxt(nxt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc <= '0;
    else        upc <= nxt;
  end

  assign mem_rd       = word.ctl.mem_rd;
  assign mem_wr       = word.ctl.mem_wr;
  assign addr_sel     = word.ctl.addr_sel;
  assign ir_load      = word.ctl.ir_load;
  assign pc_load      = word.ctl.pc_load;
  assign pc_load_cond = word.ctl.pc_load_cond;
  assign pc_src       = word.ctl.pc_src;
  assign alu_op       = word.ctl.alu_op;
  assign alu_a_sel    = word.ctl.alu_a_sel;
  assign alu_b_sel    = word.ctl.alu_b_sel;
  assign reg_wr       = word.ctl.reg_wr;
  assign reg_dst      = word.ctl.reg_dst;
  assign wb_sel       = word.ctl.wb_sel;
  assign seq_mode     = word.seq;

  // R1: first cycle out of reset starts at fetch
  assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (upc == '0));

  // R2: step code advances by one
  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode == 2'b11) |=> (upc == $past(upc) + 1'b1));

  // R3: fetch code returns to address 0
  assert_fetch_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode == 2'b00) |=> (upc == '0));

  // R4: first table only reaches its listed targets or 0
  assert_disp1_targets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode == 2'b01) |=> (upc == 4'd0 || upc == 4'd2 || upc == 4'd6 ||
                            upc == 4'd8 || upc == 4'd9));

  // R5/R6: second table reaches load read, store or 0
  assert_disp2_targets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode == 2'b10) |=> (upc == 4'd0 || upc == 4'd3 || upc == 4'd5));

  // R9: exclusive memory and PC strobes
  assert_mem_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_pc_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pc_load && pc_load_cond));
endmodule

// File: tb/useq_sequencer_bench.sv
`timescale 1ns/1ps
module useq_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'h00;
  logic [3:0] upc;
  logic       mem_rd, mem_wr, addr_sel, ir_load, pc_load, pc_load_cond;
  logic [1:0] pc_src, alu_op, alu_b_sel, seq_mode;
  logic       alu_a_sel, reg_wr, reg_dst, wb_sel;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  useq_sequencer u_useq_sequencer (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .upc(upc),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_load(ir_load),
    .pc_load(pc_load), .pc_load_cond(pc_load_cond), .pc_src(pc_src),
    .alu_op(alu_op), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .reg_wr(reg_wr), .reg_dst(reg_dst), .wb_sel(wb_sel), .seq_mode(seq_mode));

  // Vector: {opcode, trace of upc as 6 nibbles, F = end of trace}
  localparam int NVEC = 7;
  localparam logic [29:0] VECS [NVEC] = '{
    {6'h00, 24'h0167FF},   // R4 R2 R3: ALU op
    {6'h23, 24'h01234F},   // R4 R5: load
    {6'h2B, 24'h0125FF},   // R4 R5: store
    {6'h04, 24'h018FFF},   // R4: branch
    {6'h02, 24'h019FFF},   // R4: jump
    {6'h3F, 24'h01FFFF},   // R6: undefined
    {6'h08, 24'h01FFFF}    // R6: undefined
  };

  // Expected word per address, from R7/R8:
  // {mem_rd,mem_wr,addr_sel,ir_load,pc_load,pc_load_cond,pc_src,alu_op,alu_a_sel,alu_b_sel,reg_wr,reg_dst,wb_sel,seq}
  function automatic logic [17:0] exp_word(input logic [3:0] a);
    case (a)
      4'd0: exp_word = {6'b100110, 2'b00, 2'b00, 1'b0, 2'b01, 3'b000, 2'b11};
      4'd1: exp_word = {6'b000000, 2'b00, 2'b00, 1'b0, 2'b11, 3'b000, 2'b01};
      4'd2: exp_word = {6'b000000, 2'b00, 2'b00, 1'b1, 2'b10, 3'b000, 2'b10};
      4'd3: exp_word = {6'b101000, 2'b00, 2'b00, 1'b0, 2'b00, 3'b000, 2'b11};
      4'd4: exp_word = {6'b000000, 2'b00, 2'b00, 1'b0, 2'b00, 3'b101, 2'b00};
      4'd5: exp_word = {6'b011000, 2'b00, 2'b00, 1'b0, 2'b00, 3'b000, 2'b00};
      4'd6: exp_word = {6'b000000, 2'b00, 2'b10, 1'b1, 2'b00, 3'b000, 2'b11};
      4'd7: exp_word = {6'b000000, 2'b00, 2'b00, 1'b0, 2'b00, 3'b110, 2'b00};
      4'd8: exp_word = {6'b000001, 2'b01, 2'b01, 1'b1, 2'b00, 3'b000, 2'b00};
      4'd9: exp_word = {6'b000010, 2'b10, 2'b00, 1'b0, 2'b00, 3'b000, 2'b00};
      default: exp_word = '0;
    endcase
  endfunction

  function automatic logic [17:0] act_word();
    act_word = {mem_rd, mem_wr, addr_sel, ir_load, pc_load, pc_load_cond,
                pc_src, alu_op, alu_a_sel, alu_b_sel, reg_wr, reg_dst, wb_sel,
                seq_mode};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_step(input string tag, input logic [3:0] a);
    chk({tag, " upc"}, 32'(upc), 32'(a));
    chk({tag, " R8 fields"}, 32'(act_word()), 32'(exp_word(a)));
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    #3;
    chk_step("R1 in reset", 4'd0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_step("R1 after release", 4'd1);
    @(negedge clk);
    chk("R6 undefined-free decode path", 32'(upc), 32'd6); // opcode 00 -> ALU execute
    @(negedge clk); @(negedge clk);
    chk("R3 back to fetch", 32'(upc), 32'd0);

    // Vector walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      opcode = VECS[i][29:24];
      for (int k = 0; k < 6; k++) begin
        logic [3:0] nib;
        nib = VECS[i][23 - 4*k -: 4];
        if (nib == 4'hF) break;
        if (k > 0) @(negedge clk);
        chk_step($sformatf("R4/R5 vec%0d step%0d", i, k), nib);
      end
      @(negedge clk);
    end
    chk("R3 R6 returns to fetch", 32'(upc), 32'd0);

    // R5: second table reads live opcode (load decoded, store at address 2)
    opcode = 6'h23;
    @(negedge clk); @(negedge clk);
    chk("R4 at address compute", 32'(upc), 32'd2);
    opcode = 6'h2B;
    @(negedge clk);
    chk_step("R5 live opcode store", 4'd5);
    @(negedge clk);
    chk("R3 after store", 32'(upc), 32'd0);

    // R6: miss in second table
    opcode = 6'h23;
    @(negedge clk); @(negedge clk);
    opcode = 6'h00;
    @(negedge clk);
    chk_step("R6 table2 miss", 4'd0);

    // R1: asynchronous reset mid-instruction
    opcode = 6'h23;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R2 load read reached", 32'(upc), 32'd3);
    rst_n = 1'b0;
    #1;
    chk_step("R1 async clear", 4'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 restart decode", 32'(upc), 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule